// File: doc/BRIEF.md
# Reset Sequencer with Cause Detection

This block owns the reset of a small microcontroller. It holds the internal reset after power-up until the oscillator has had time to settle. It watches a bidirectional open-drain reset pin for reset requests from outside the chip. When the watchdog or the clock monitor raises a one-cycle fault pulse, the block pulls the pin low itself, so that the rest of the board is reset along with the chip.

An internally caused reset drives the pin for a fixed number of cycles. The block then releases the pin, waits, and samples the pin again. A pin that is still low at that sample means that something outside is also holding reset, and the sequence ends as an external reset. A pin that has gone high keeps the latched internal cause. When the internal reset is released, the block presents the address of the reset vector that matches the cause. The address stays constant until the next reset ends.

Control is a five-state machine:
- `ST_POR` counts the power-up delay.
- `ST_RUN` is normal operation. It waits for a fault pulse or a filtered pin request.
- `ST_EXT_HOLD` holds reset until the pin reads high.
- `ST_DRIVE` pulls the pin low.
- `ST_SETTLE` waits with the pin released and then samples it.

The transitions are:
- POR-done goes from `ST_POR` to `ST_RUN`, or to `ST_EXT_HOLD` if the pin is low at that point.
- Fault-seen goes from `ST_RUN` to `ST_DRIVE`.
- Pin-request goes from `ST_RUN` to `ST_EXT_HOLD`.
- Pin-released goes from `ST_EXT_HOLD` to `ST_RUN`.
- Drive-done goes from `ST_DRIVE` to `ST_SETTLE`.
- Sample-high goes from `ST_SETTLE` to `ST_RUN`.
- Sample-low goes from `ST_SETTLE` to `ST_EXT_HOLD`.

Top module: `rst_sequencer`

## Requirements
- R1: While `por_n` is low, and for exactly POR_CYCLES (default 8192) rising clock edges after it goes high, `rst_int` is 1 and `pin_pull` is 0. During that time `vector` reads 0xFFFE.
- R2: In normal operation, a reset request from the pin is recognised only after `pin_in` has been sampled low on more than PIN_MIN_LOW-1 consecutive edges. With the default of 3, the pin must read low on 3 edges, and `rst_int` rises after the next edge. A low lasting only 2 edges leaves `rst_int` at 0.
- R3: A reset that has become external ends only when the pin is released. `rst_int` falls after the first edge that samples `pin_in` high, with no added stabilisation delay. The same rule applies at the end of the power-up count.
- R4: A fault pulse in normal operation sets `rst_int` and `pin_pull` after the next edge. `pin_pull` then stays 1 for exactly DRIVE_CYCLES (default 64) edges. `pin_pull` is never 1 while `rst_int` is 0.
- R5: SAMPLE_DELAY (default 32) edges after the pin is released, the pin is sampled. If it reads high, `rst_int` falls after that edge. With the defaults, this is 96 edges after the fault edge. If it reads low, the reset becomes external.
- R6: The `vector` encoding depends on the cause. It is 0xFFFE for power-up or external reset, 0xFFFC for a clock-monitor fault and 0xFFFA for a watchdog fault. No other value appears.
- R7: If clock-monitor and watchdog pulses arrive on the same edge, the clock-monitor cause wins.
- R8: Fault pulses that arrive while any reset is in progress are ignored. This covers the power-up count and the drive and settle phases. They change neither the timing nor the cause.
- R9: `vector` changes only on the edge that ends a reset sequence. It is stable while `rst_int` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on indication, active low, asynchronous |
| pin_in | input | 1 | Sampled level of the reset pin (1 = released) |
| wdog_fault | input | 1 | One-cycle watchdog time-out pulse |
| clkmon_fault | input | 1 | One-cycle clock-monitor failure pulse |
| pin_pull | output | 1 | Enable of the open-drain pull-down on the reset pin |
| rst_int | output | 1 | Internal reset, active high |
| vector | output | 16 | Reset vector address for the latched cause |

## Verification
The two internal fault sources can fire on the same edge. The bench pulses `clkmon_fault` and `wdog_fault` together in the same cycle and expects the whole sequence to end with the clock-monitor vector 0xFFFC.

A second collision happens inside a single sequence, between the block's own pull-down and an outside driver. The bench keeps the pin low past the release point. It checks that `rst_int` is still held one cycle after the sample edge and falls only once the outside driver lets go, with the result reported as an external reset.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    localparam int VEC_W = 16;

    typedef enum logic [2:0] {
        ST_POR,
        ST_RUN,
        ST_EXT_HOLD,
        ST_DRIVE,
        ST_SETTLE
    } seq_state_e;

    typedef enum logic [1:0] {
        CAUSE_POR,
        CAUSE_EXT,
        CAUSE_WDOG,
        CAUSE_CMON
    } cause_e;

    localparam logic [VEC_W-1:0] VEC_PWR_EXT = 16'hFFFE;
    localparam logic [VEC_W-1:0] VEC_CMON    = 16'hFFFC;
    localparam logic [VEC_W-1:0] VEC_WDOG    = 16'hFFFA;

endpackage

// File: rtl/rst_step_counter.sv
module rst_step_counter #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] count
);
    // Free-running up-counter: cleared when the controller asks for it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
    parameter int MIN_LOW = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic low_long
);
    localparam int FW = $clog2(MIN_LOW + 1);
    localparam logic [FW-1:0] FULL = FW'(MIN_LOW);

    logic [FW-1:0] low_cnt;

    // Counts consecutive low samples, saturating at MIN_LOW.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (pin_in) begin
            low_cnt <= '0;
        end else if (low_cnt != FULL) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign low_long = (low_cnt == FULL);
endmodule

// File: rtl/rst_vector_sel.sv
module rst_vector_sel
    import rst_seq_pkg::*;
(
    input  cause_e           cause,
    output logic [VEC_W-1:0] vec
);
    always_comb begin
        unique case (cause)
            CAUSE_CMON: vec = VEC_CMON;
            CAUSE_WDOG: vec = VEC_WDOG;
            default:    vec = VEC_PWR_EXT;
        endcase
    end
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
    import rst_seq_pkg::*;
#(
    parameter int POR_CYCLES   = 8192,
    parameter int PIN_MIN_LOW  = 3,
    parameter int DRIVE_CYCLES = 64,
    parameter int SAMPLE_DELAY = 32
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              pin_in,
    input  logic              wdog_fault,
    input  logic              clkmon_fault,
    output logic              pin_pull,
    output logic              rst_int,
    output logic [VEC_W-1:0]  vector
);
    localparam int CNT_MAX = (POR_CYCLES > DRIVE_CYCLES)
                           ? ((POR_CYCLES > SAMPLE_DELAY) ? POR_CYCLES : SAMPLE_DELAY)
                           : ((DRIVE_CYCLES > SAMPLE_DELAY) ? DRIVE_CYCLES : SAMPLE_DELAY);
    localparam int CNT_W = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] POR_LAST    = CNT_W'(POR_CYCLES - 1);
    localparam logic [CNT_W-1:0] DRIVE_LAST  = CNT_W'(DRIVE_CYCLES - 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SAMPLE_DELAY - 1);

    seq_state_e        state_q, state_d;
    cause_e            cause_q, cause_d;
    logic [CNT_W-1:0]  cnt;
    logic              cnt_clr;
    logic              pin_low_long;
    logic [VEC_W-1:0]  vec_sel;
    logic [VEC_W-1:0]  vec_q;

    rst_step_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (por_n),
        .clr   (cnt_clr),
        .count (cnt)
    );

    rst_pin_filter #(.MIN_LOW(PIN_MIN_LOW)) u_filt (
        .clk      (clk),
        .rst_n    (por_n),
        .pin_in   (pin_in),
        .low_long (pin_low_long)
    );

    rst_vector_sel u_vsel (
        .cause (cause_q),
        .vec   (vec_sel)
    );

    // State and cause register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_POR;
            cause_q <= CAUSE_POR;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cause_d = cause_q;
        cnt_clr = 1'b0;
        unique case (state_q)
            ST_POR: begin
                if (cnt == POR_LAST) begin
                    cnt_clr = 1'b1;
                    if (pin_in) begin
                        state_d = ST_RUN;
                    end else begin
                        state_d = ST_EXT_HOLD;
                        cause_d = CAUSE_EXT;
                    end
                end
            end
            ST_RUN: begin
                cnt_clr = 1'b1;
                if (clkmon_fault) begin
                    state_d = ST_DRIVE;
                    cause_d = CAUSE_CMON;
                end else if (wdog_fault) begin
                    state_d = ST_DRIVE;
                    cause_d = CAUSE_WDOG;
                end else if (pin_low_long) begin
                    state_d = ST_EXT_HOLD;
                    cause_d = CAUSE_EXT;
                end
            end
            ST_EXT_HOLD: begin
                cnt_clr = 1'b1;
                if (pin_in) begin
                    state_d = ST_RUN;
                end
            end
            ST_DRIVE: begin
                if (cnt == DRIVE_LAST) begin
                    cnt_clr = 1'b1;
                    state_d = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (cnt == SETTLE_LAST) begin
                    cnt_clr = 1'b1;
                    if (pin_in) begin
                        state_d = ST_RUN;
                    end else begin
                        state_d = ST_EXT_HOLD;
                        cause_d = CAUSE_EXT;
                    end
                end
            end
            default: begin
                state_d = ST_POR;
                cnt_clr = 1'b1;
            end
        endcase
    end

    // Vector register: loaded only when a sequence ends
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            vec_q <= VEC_PWR_EXT;
        end else if (state_d == ST_RUN && state_q != ST_RUN) begin
            vec_q <= vec_sel;
        end
    end

    // Outputs
    always_comb begin
        rst_int  = 1'b1;
        pin_pull = 1'b0;
        unique case (state_q)
            ST_RUN:   rst_int  = 1'b0;
            ST_DRIVE: pin_pull = 1'b1;
            default:  ;
        endcase
    end

    assign vector = vec_q;

endmodule

// File: rtl/rst_sequencer_chk.sv
module rst_sequencer_chk #(
    parameter int POR_CYCLES   = 8192,
    parameter int DRIVE_CYCLES = 64
) (
    input logic        clk,
    input logic        por_n,
    input logic        pin_in,
    input logic        wdog_fault,
    input logic        clkmon_fault,
    input logic        pin_pull,
    input logic        rst_int,
    input logic [15:0] vector
);
    int por_age;
    int drive_len;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            por_age   <= 0;
            drive_len <= 0;
        end else begin
            if (por_age < POR_CYCLES) por_age <= por_age + 1;
            drive_len <= pin_pull ? drive_len + 1 : 0;
        end
    end

    assert_por_hold_R1: assert property (@(posedge clk) disable iff (!por_n)
        (por_age < POR_CYCLES) |-> (rst_int && !pin_pull));

    assert_release_on_high_R3: assert property (@(posedge clk) disable iff (!por_n)
        $fell(rst_int) |-> $past(pin_in));

    assert_fault_starts_drive_R4: assert property (@(posedge clk) disable iff (!por_n)
        (!rst_int && (wdog_fault || clkmon_fault)) |=> (pin_pull && rst_int));

    assert_drive_length_R4: assert property (@(posedge clk) disable iff (!por_n)
        $fell(pin_pull) |-> (drive_len == DRIVE_CYCLES));

    assert_pull_only_in_reset_R4: assert property (@(posedge clk) disable iff (!por_n)
        pin_pull |-> rst_int);

    assert_vector_legal_R6: assert property (@(posedge clk) disable iff (!por_n)
        (vector == 16'hFFFE) || (vector == 16'hFFFC) || (vector == 16'hFFFA));

    assert_vector_stable_R9: assert property (@(posedge clk) disable iff (!por_n)
        (!rst_int && $past(!rst_int)) |-> $stable(vector));

endmodule

bind rst_sequencer rst_sequencer_chk #(
    .POR_CYCLES   (POR_CYCLES),
    .DRIVE_CYCLES (DRIVE_CYCLES)
) u_chk (
    .clk          (clk),
    .por_n        (por_n),
    .pin_in       (pin_in),
    .wdog_fault   (wdog_fault),
    .clkmon_fault (clkmon_fault),
    .pin_pull     (pin_pull),
    .rst_int      (rst_int),
    .vector       (vector)
);

// File: tb/rst_sequencer_test.sv
`timescale 1ns/1ps
module rst_sequencer_test;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        wdog_fault = 1'b0;
    logic        clkmon_fault = 1'b0;
    logic        ext_low = 1'b0;
    logic        pin_pull;
    logic        rst_int;
    logic [15:0] vector;
    logic        pin_in;

    int checks = 0;
    int errors = 0;

    // open-drain pin: low if the block or an outside driver pulls it
    assign pin_in = !(pin_pull || ext_low);

    always #4 clk = ~clk;

    rst_sequencer uut (
        .clk          (clk),
        .por_n        (por_n),
        .pin_in       (pin_in),
        .wdog_fault   (wdog_fault),
        .clkmon_fault (clkmon_fault),
        .pin_pull     (pin_pull),
        .rst_int      (rst_int),
        .vector       (vector)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // fields: kind[18:17] (1 watchdog, 2 clock monitor, 3 both), ext[16], vec[15:0]
    localparam logic [18:0] TBL [5] = '{
        {2'd1, 1'b0, 16'hFFFA},
        {2'd2, 1'b0, 16'hFFFC},
        {2'd3, 1'b0, 16'hFFFC},
        {2'd1, 1'b1, 16'hFFFE},
        {2'd2, 1'b1, 16'hFFFE}
    };

    task automatic fault_seq(input logic [1:0] kind, input logic ext,
                             input logic [15:0] exp_vec, input logic inject);
        @(negedge clk);
        wdog_fault   = kind[0];
        clkmon_fault = kind[1];
        @(negedge clk);                       // N1
        wdog_fault   = 1'b0;
        clkmon_fault = 1'b0;
        check("R4 pull starts", {31'd0, pin_pull}, 32'd1);
        check("R4 reset starts", {31'd0, rst_int}, 32'd1);
        repeat (8) @(negedge clk);
        if (inject) begin                     // R8: pulses during drive are ignored
            clkmon_fault = 1'b1;
            @(negedge clk);
            clkmon_fault = 1'b0;
            repeat (54) @(negedge clk);
        end else begin
            repeat (55) @(negedge clk);       // N64
        end
        check("R4 pull last cycle", {31'd0, pin_pull}, 32'd1);
        @(negedge clk);                       // N65
        check("R4 pull released", {31'd0, pin_pull}, 32'd0);
        if (ext) ext_low = 1'b1;
        repeat (31) @(negedge clk);           // N96
        check("R5 held before sample", {31'd0, rst_int}, 32'd1);
        @(negedge clk);                       // N97
        if (!ext) begin
            check("R5 release after sample", {31'd0, rst_int}, 32'd0);
        end else begin
            check("R5 low sample keeps reset", {31'd0, rst_int}, 32'd1);
            repeat (5) @(negedge clk);
            check("R3 hold while pin low", {31'd0, rst_int}, 32'd1);
            ext_low = 1'b0;
            @(negedge clk);
            check("R3 release on pin high", {31'd0, rst_int}, 32'd0);
        end
        check("R6 R7 vector", {16'd0, vector}, {16'd0, exp_vec});
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] held;
        repeat (3) @(negedge clk);
        check("R1 reset state rst_int", {31'd0, rst_int}, 32'd1);
        check("R1 reset state pull", {31'd0, pin_pull}, 32'd0);
        check("R1 reset state vector", {16'd0, vector}, 32'h0000FFFE);
        por_n = 1'b1;                         // N0
        repeat (100) @(negedge clk);
        wdog_fault = 1'b1;                    // R8: ignored during power-up count
        @(negedge clk);
        wdog_fault = 1'b0;
        check("R8 no pull in power-up", {31'd0, pin_pull}, 32'd0);
        repeat (8090) @(negedge clk);         // N8191
        check("R1 held at last count", {31'd0, rst_int}, 32'd1);
        @(negedge clk);                       // N8192
        check("R1 released", {31'd0, rst_int}, 32'd0);
        check("R1 vector", {16'd0, vector}, 32'h0000FFFE);
        repeat (4) @(negedge clk);

        for (int i = 0; i < 5; i++) begin
            fault_seq(TBL[i][18:17], TBL[i][16], TBL[i][15:0], 1'b0);
        end

        // R8: clock-monitor pulse inside a watchdog sequence does not change cause
        fault_seq(2'd1, 1'b0, 16'hFFFA, 1'b1);

        // R9: vector stays put while running
        held = vector;
        repeat (20) @(negedge clk);
        check("R9 vector stable", {16'd0, vector}, {16'd0, held});

        // R2: two-cycle low is ignored
        ext_low = 1'b1;
        repeat (2) @(negedge clk);
        ext_low = 1'b0;
        repeat (4) @(negedge clk);
        check("R2 short low ignored", {31'd0, rst_int}, 32'd0);
        check("R2 R9 vector after glitch", {16'd0, vector}, 32'h0000FFFA);

        // R2: three-cycle low is recognised, R3: wait for release
        ext_low = 1'b1;                       // N0
        repeat (3) @(negedge clk);
        check("R2 not yet after third low", {31'd0, rst_int}, 32'd0);
        @(negedge clk);
        check("R2 external reset seen", {31'd0, rst_int}, 32'd1);
        check("R2 no pull on external", {31'd0, pin_pull}, 32'd0);
        repeat (6) @(negedge clk);
        check("R3 held while pin low", {31'd0, rst_int}, 32'd1);
        ext_low = 1'b0;
        @(negedge clk);
        check("R3 released without delay", {31'd0, rst_int}, 32'd0);
        check("R6 external vector", {16'd0, vector}, 32'h0000FFFE);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule